// File: doc/BRIEF.md
# Overload Fault Timer and Protection Sequencer

This block is the digital protection core of a fixed-frequency current-mode power controller. It decides whether the gate driver may switch. The analog front end gives it conditions as logic flags. One flag says the peak-current setpoint sat at its clamp during a switching period. Another says the period ended on the maximum-duty limit. A third says the sensed current crossed the hard-stop level, which is 1.5 times the clamp. The last two come from a two-sided latch-off pin and show whether it was pulled above its high level or below its low level. The block also holds a stepped soft-start generator. At every start this generator raises the allowed peak-current setpoint from zero to the clamp level, one code at a time.

Sustained overload is caught by a timer. The timer starts at the end of the first clamped period and is cleared by any period that ends below the clamp. Periods that the duty limit ended are not counted either way. If the current crosses the hard-stop level once the blanking window after the pulse start has passed, the block enters protection at once. In the latched build, overload protection lasts until a supply reset. In the auto-recovery build, the block waits a fixed time, raises a one-cycle restart request and starts again with a new soft-start. A latch-pin event locks the block off in both builds, and only a supply reset releases it. The low-level pin condition is not acted on while soft-start runs. All durations are parameters counted in clock cycles.

Top module: `ovl_prot_seq`

## Requirements
- R1: During and right after reset, drive_en_o is 1, prot_o is 0, restart_o is 0 and setpoint_o is 0.
- R2: While running, setpoint_o starts at 0 and rises by one every SS_STEP_CYCLES clocks until it reaches 15. It then holds at 15. Soft-start counts as active while the code is below 15.
- R3: A cycle_end_i strobe with clamp_hit_i=1 and duty_end_i=0 arms the overload timer. If no clearing strobe follows, prot_o rises on the OVL_CYCLES+1-th clock edge after the edge that sampled the strobe.
- R4: A cycle_end_i strobe with clamp_hit_i=0 and duty_end_i=0 disarms the timer and clears it. The next clamped strobe starts a full duration again.
- R5: A cycle_end_i strobe with duty_end_i=1 neither arms, clears nor disarms the timer, whatever the value of clamp_hit_i.
- R6: cs_over_i is ignored during the first BLANK_CYCLES clock edges of a pulse_on_i pulse. Once pulse_on_i has been high for BLANK_CYCLES edges, cs_over_i=1 sets prot_o on the next edge. Without pulse_on_i, cs_over_i has no effect.
- R7: In the latched build (AUTO_RECOVER=0), prot_o stays at 1 until a sup_reset_i edge. sup_reset_i returns the block to running with setpoint_o at 0 and starts a fresh ramp.
- R8: In the auto-recovery build, restart_o pulses for one cycle after REC_CYCLES edges spent in overload protection. drive_en_o returns on that edge with setpoint_o at 0. A repeated fault produces the same timing again.
- R9: pin_high_i=1 while running locks the block off. It never recovers on its own, even in the auto-recovery build, and only sup_reset_i releases it.
- R10: pin_low_i=1 locks the block off only when setpoint_o is 15 at the sampling edge. It is ignored while soft-start is active.
- R11: While prot_o is 1, drive_en_o is 0 and setpoint_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_end_i | input | 1 | One-cycle strobe at the end of each switching period |
| clamp_hit_i | input | 1 | The period's setpoint sat at the limit clamp (read with cycle_end_i) |
| duty_end_i | input | 1 | The period was ended by the maximum-duty limit (read with cycle_end_i) |
| pulse_on_i | input | 1 | Gate pulse in progress, used to time the hard-stop blanking |
| cs_over_i | input | 1 | Sensed current above the hard-stop level |
| pin_high_i | input | 1 | Latch-off pin above its high threshold |
| pin_low_i | input | 1 | Latch-off pin below its low threshold |
| sup_reset_i | input | 1 | Supply reset: clears any protection and restarts soft-start |
| drive_en_o | output | 1 | Switching allowed |
| prot_o | output | 1 | Protection (fault or lock) active |
| restart_o | output | 1 | One-cycle auto-recovery restart request |
| setpoint_o | output | 4 | Soft-start setpoint step code, 0 to 15 |

## Verification
The hardest case to reach from the ports is a fault timer that has run a long way through mixed periods. A clamp-free period or a duty-limited period can land on any count, including the one just before expiry. To reach it, the bench sends random runs of period-end strobes with random spacing. Each strobe is drawn as clamped, unclamped or duty-limited. A bench model of the arm, clear and ignore rules predicts the exact edge where latched protection must appear. Directed cases add the remaining edges: the last blanked edge of a pulse, and the last code of soft-start where a low pin level is still ignored.

// File: rtl/prot_seq_pkg.sv
// Shared types for the protection sequencer.
// Assumes: nothing; only types live here.
package prot_seq_pkg;
    // Sequencer states: switching, overload fault, pin lock-off.
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_FAULT = 2'd1,
        PS_LOCK  = 2'd2
    } prot_state_t;
endpackage

// File: rtl/ovl_timer.sv
// Overload timer. A period-end strobe that reports a clamped setpoint arms it,
// an unclamped one disarms and clears it, and a duty-limited one is skipped.
// While armed it counts clocks and flags expiry at OVL_CYCLES.
// Assumes: OVL_CYCLES >= 1; clr_i holds it idle outside the running state.
module ovl_timer #(
    parameter int unsigned OVL_CYCLES = 128000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic evt_i,
    input  logic clamp_i,
    input  logic duty_i,
    output logic expire_o
);
    localparam int unsigned CW = $clog2(OVL_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(OVL_CYCLES);

    logic          armed;
    logic [CW-1:0] cnt;

    // Arm, clear or advance the overload count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (evt_i && !duty_i) begin
            armed <= clamp_i;
            if (!clamp_i) begin
                cnt <= '0;
            end else if (armed && cnt != LIM) begin
                cnt <= cnt + 1'b1;
            end
        end else if (armed && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry flag, read by the sequencer on the next edge.
    always_comb expire_o = armed && (cnt == LIM);
endmodule

// File: rtl/hs_blanker.sv
// Hard-stop blanking. It counts clock edges since the gate pulse started and
// passes the over-current flag on only after BLANK_CYCLES edges.
// Assumes: BLANK_CYCLES >= 1; pulse_on_i falls between pulses.
module hs_blanker #(
    parameter int unsigned BLANK_CYCLES = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_on_i,
    input  logic cs_over_i,
    output logic trip_o
);
    localparam int unsigned BW = $clog2(BLANK_CYCLES + 1);
    localparam logic [BW-1:0] LIM = BW'(BLANK_CYCLES);

    logic [BW-1:0] bcnt;

    // Time the pulse since its start, saturating at the blanking length.
    always_ff @(posedge clk) begin
        if (!rst_n || !pulse_on_i) begin
            bcnt <= '0;
        end else if (bcnt != LIM) begin
            bcnt <= bcnt + 1'b1;
        end
    end

    // Unblanked hard-stop request.
    always_comb trip_o = pulse_on_i && cs_over_i && (bcnt == LIM);
endmodule

// File: rtl/ss_ramp.sv
// Stepped soft-start generator. The code rises from 0 to its top value, one
// step every STEP_CYCLES clocks, then holds. clr_i restarts it from 0.
// Assumes: STEP_CYCLES >= 1.
module ss_ramp #(
    parameter int unsigned CODE_W      = 4,
    parameter int unsigned STEP_CYCLES = 267
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    output logic [CODE_W-1:0] code_o,
    output logic              active_o
);
    localparam int unsigned TW = $clog2(STEP_CYCLES + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(STEP_CYCLES - 1);
    localparam logic [CODE_W-1:0] CODE_TOP = '1;

    logic [TW-1:0] tick;

    // Advance the step code on each completed step interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            tick   <= '0;
            code_o <= '0;
        end else if (code_o != CODE_TOP) begin
            if (tick == TICK_LAST) begin
                tick   <= '0;
                code_o <= code_o + 1'b1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    // Soft-start is in progress until the top code is reached.
    always_comb active_o = (code_o != CODE_TOP);
endmodule

// File: rtl/ovl_prot_seq.sv
// Protection sequencer top. It merges the overload timer, the blanked hard
// stop and the two-sided latch pin into one switching permission. In the
// auto-recovery build it re-launches after a fixed wait. Pin lock-off and
// latched overload are released only by the supply reset.
// Assumes: inputs are synchronous to clk; REC_CYCLES >= 2.
module ovl_prot_seq
    import prot_seq_pkg::*;
#(
    parameter int unsigned OVL_CYCLES    = 128000,
    parameter int unsigned BLANK_CYCLES  = 30,
    parameter int unsigned REC_CYCLES    = 1000000,
    parameter int unsigned SS_STEP_CYCLES = 267,
    parameter int unsigned CODE_W        = 4,
    parameter bit          AUTO_RECOVER  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_end_i,
    input  logic              clamp_hit_i,
    input  logic              duty_end_i,
    input  logic              pulse_on_i,
    input  logic              cs_over_i,
    input  logic              pin_high_i,
    input  logic              pin_low_i,
    input  logic              sup_reset_i,
    output logic              drive_en_o,
    output logic              prot_o,
    output logic              restart_o,
    output logic [CODE_W-1:0] setpoint_o
);
    prot_state_t state, state_d;
    logic        ovl_expire;
    logic        hs_trip;
    logic        ss_active;
    logic        rec_done;
    logic        blk_clr;
    logic        restart_d;

    // Next state: supply reset wins, then pin lock, then fault sources.
    always_comb begin
        state_d   = state;
        restart_d = 1'b0;
        if (sup_reset_i) begin
            state_d = PS_RUN;
        end else begin
            case (state)
                PS_RUN: begin
                    if (pin_high_i || (pin_low_i && !ss_active)) begin
                        state_d = PS_LOCK;
                    end else if (hs_trip || ovl_expire) begin
                        state_d = PS_FAULT;
                    end
                end
                PS_FAULT: begin
                    if (rec_done) begin
                        state_d   = PS_RUN;
                        restart_d = 1'b1;
                    end
                end
                default: state_d = state;
            endcase
        end
    end

    // Hold the sub-blocks idle when not running or when leaving the run state.
    always_comb blk_clr = sup_reset_i || (state != PS_RUN) || (state_d != PS_RUN);

    // State and restart-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PS_RUN;
            restart_o <= 1'b0;
        end else begin
            state     <= state_d;
            restart_o <= restart_d;
        end
    end

    // The recovery wait exists only in the auto-recovery build.
    generate
        if (AUTO_RECOVER) begin : g_auto
            localparam int unsigned RW = $clog2(REC_CYCLES + 1);
            localparam logic [RW-1:0] REC_LAST = RW'(REC_CYCLES - 1);
            logic [RW-1:0] rcnt;

            // Count clocks spent in overload protection.
            always_ff @(posedge clk) begin
                if (!rst_n || state != PS_FAULT) begin
                    rcnt <= '0;
                end else if (rcnt != REC_LAST) begin
                    rcnt <= rcnt + 1'b1;
                end
            end

            always_comb rec_done = (state == PS_FAULT) && (rcnt == REC_LAST);
        end else begin : g_latched
            always_comb rec_done = 1'b0;
        end
    endgenerate

    ovl_timer #(
        .OVL_CYCLES(OVL_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (blk_clr),
        .evt_i    (cycle_end_i),
        .clamp_i  (clamp_hit_i),
        .duty_i   (duty_end_i),
        .expire_o (ovl_expire)
    );

    hs_blanker #(
        .BLANK_CYCLES(BLANK_CYCLES)
    ) u_blank (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_on_i (pulse_on_i),
        .cs_over_i  (cs_over_i),
        .trip_o     (hs_trip)
    );

    ss_ramp #(
        .CODE_W      (CODE_W),
        .STEP_CYCLES (SS_STEP_CYCLES)
    ) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (blk_clr),
        .code_o   (setpoint_o),
        .active_o (ss_active)
    );

    // Output decode.
    always_comb begin
        drive_en_o = (state == PS_RUN);
        prot_o     = (state != PS_RUN);
    end
endmodule

// File: rtl/ovl_prot_seq_chk.sv
// Assertion checker for the protection sequencer, bound into every instance.
// Assumes: the internal trip flags of the top are visible through the bind.
module ovl_prot_seq_chk #(
    parameter int unsigned CODE_W       = 4,
    parameter bit          AUTO_RECOVER = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sup_reset_i,
    input logic              pin_high_i,
    input logic              pin_low_i,
    input logic              drive_en_o,
    input logic              prot_o,
    input logic              restart_o,
    input logic [CODE_W-1:0] setpoint_o,
    input logic              hs_trip,
    input logic              ovl_expire
);
    localparam logic [CODE_W-1:0] TOP = '1;

    // R11
    sp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_o |-> (setpoint_o == '0));

    // R2
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_o && !sup_reset_i) |=> (!drive_en_o || setpoint_o == $past(setpoint_o)
            || setpoint_o == CODE_W'($past(setpoint_o) + 1'b1)));

    // R8
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o);

    // R8
    restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> $past(prot_o));

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!AUTO_RECOVER && prot_o && !sup_reset_i) |=> prot_o);

    // R3
    ovl_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_expire && drive_en_o && !sup_reset_i) |=> prot_o);

    // R6
    hs_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_trip && drive_en_o && !sup_reset_i) |=> prot_o);

    // R9
    pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_high_i && drive_en_o && !sup_reset_i) |=> (prot_o && !restart_o));

    // R10
    pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_low_i && drive_en_o && setpoint_o != TOP && !sup_reset_i
         && !pin_high_i && !hs_trip && !ovl_expire) |=> drive_en_o);
endmodule

bind ovl_prot_seq ovl_prot_seq_chk #(
    .CODE_W       (CODE_W),
    .AUTO_RECOVER (AUTO_RECOVER)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_reset_i (sup_reset_i),
    .pin_high_i  (pin_high_i),
    .pin_low_i   (pin_low_i),
    .drive_en_o  (drive_en_o),
    .prot_o      (prot_o),
    .restart_o   (restart_o),
    .setpoint_o  (setpoint_o),
    .hs_trip     (hs_trip),
    .ovl_expire  (ovl_expire)
);

// File: tb/tb_ovl_prot_seq.sv
// Bench for the protection sequencer: one auto-recovery and one latched copy
// share the stimulus. Directed corners plus seeded random period-end runs.
module tb_ovl_prot_seq;
    localparam int OVL = 40;
    localparam int BLK = 3;
    localparam int REC = 60;
    localparam int SS  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_end = 1'b0, clamp = 1'b0, duty = 1'b0;
    logic pulse_on = 1'b0, cs_over = 1'b0;
    logic pin_hi = 1'b0, pin_lo = 1'b0, sup_rst = 1'b0;
    logic a_drive, a_prot, a_rst;
    logic l_drive, l_prot, l_rst;
    logic [3:0] a_sp, l_sp;

    int checks = 0;
    int errors = 0;
    int ec = 0;

    always #2 clk = ~clk;

    ovl_prot_seq #(.OVL_CYCLES(OVL), .BLANK_CYCLES(BLK), .REC_CYCLES(REC),
                   .SS_STEP_CYCLES(SS), .CODE_W(4), .AUTO_RECOVER(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cycle_end_i(cyc_end), .clamp_hit_i(clamp),
        .duty_end_i(duty), .pulse_on_i(pulse_on), .cs_over_i(cs_over),
        .pin_high_i(pin_hi), .pin_low_i(pin_lo), .sup_reset_i(sup_rst),
        .drive_en_o(a_drive), .prot_o(a_prot), .restart_o(a_rst), .setpoint_o(a_sp));

    ovl_prot_seq #(.OVL_CYCLES(OVL), .BLANK_CYCLES(BLK), .REC_CYCLES(REC),
                   .SS_STEP_CYCLES(SS), .CODE_W(4), .AUTO_RECOVER(1'b0)) dut_l (
        .clk(clk), .rst_n(rst_n), .cycle_end_i(cyc_end), .clamp_hit_i(clamp),
        .duty_end_i(duty), .pulse_on_i(pulse_on), .cs_over_i(cs_over),
        .pin_high_i(pin_hi), .pin_low_i(pin_lo), .sup_reset_i(sup_rst),
        .drive_en_o(l_drive), .prot_o(l_prot), .restart_o(l_rst), .setpoint_o(l_sp));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ec++;
        end
    endtask

    task automatic cend(input bit c, input bit d);
        cyc_end = 1'b1; clamp = c; duty = d;
        step(1);
        cyc_end = 1'b0; clamp = 1'b0; duty = 1'b0;
    endtask

    task automatic supr();
        sup_rst = 1'b1;
        step(1);
        sup_rst = 1'b0;
    endtask

    // Expected latched protection under the arm/clear/skip rules.
    function automatic bit exp_trip(input bit armed, input int start, input int now);
        return armed && (now >= start + OVL + 1);
    endfunction

    initial begin
        void'($urandom(32'd4242));
        step(2);
        // R1 during reset
        chk("R1 drive in reset", a_drive, 1);
        chk("R1 prot in reset", a_prot, 0);
        chk("R1 setpoint in reset", a_sp, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 restart after reset", a_rst, 0);
        chk("R1 prot after reset", l_prot, 0);

        // R2 ramp timing from the release edge
        step(SS - 2);
        chk("R2 code before first step", a_sp, 0);
        step(1);
        chk("R2 first step", a_sp, 1);
        step(14 * SS);
        chk("R2 top code", a_sp, 15);
        step(20);
        chk("R2 hold at top", l_sp, 15);

        // R3 overload timing, both builds
        cend(1'b1, 1'b0);
        step(OVL);
        chk("R3 not yet tripped", a_prot, 0);
        chk("R3 not yet tripped latched", l_prot, 0);
        step(1);
        chk("R3 tripped", a_prot, 1);
        chk("R3 tripped latched", l_prot, 1);
        chk("R11 drive off", a_drive, 0);
        chk("R11 setpoint zero", l_sp, 0);

        // R8 auto recovery timing
        step(REC - 1);
        chk("R8 still waiting", a_prot, 1);
        chk("R8 no early restart", a_rst, 0);
        step(1);
        chk("R8 running again", a_prot, 0);
        chk("R8 restart pulse", a_rst, 1);
        chk("R8 ramp from zero", a_sp, 0);
        step(1);
        chk("R8 pulse one cycle", a_rst, 0);
        chk("R7 latched holds", l_prot, 1);
        chk("R7 latched no restart", l_rst, 0);

        // R8 repeated fault repeats timing
        cend(1'b1, 1'b0);
        step(OVL);
        chk("R8 repeat not yet", a_prot, 0);
        step(1);
        chk("R8 repeat tripped", a_prot, 1);

        // R7 supply reset releases the latched build
        supr();
        chk("R7 released", l_prot, 0);
        chk("R7 drive back", l_drive, 1);
        chk("R7 ramp restart", l_sp, 0);
        step(SS);
        chk("R7 ramp stepping", l_sp, 1);

        // R4 clearing period restarts the full duration
        cend(1'b1, 1'b0);
        step(20);
        cend(1'b0, 1'b0);
        cend(1'b1, 1'b0);
        step(OVL);
        chk("R4 full duration again", l_prot, 0);
        step(1);
        chk("R4 trip after restart", l_prot, 1);
        supr();

        // R5 duty-limited end does not clear a running timer
        cend(1'b1, 1'b0);
        step(10);
        cend(1'b0, 1'b1);
        step(OVL - 11);
        chk("R5 not yet", l_prot, 0);
        step(1);
        chk("R5 duty end ignored", l_prot, 1);
        supr();
        // R5 duty-limited clamped end does not arm
        cend(1'b1, 1'b1);
        step(OVL + 10);
        chk("R5 duty end did not arm", l_prot, 0);
        chk("R5 duty end did not arm auto", a_prot, 0);

        // R6 hard stop blanking
        cs_over = 1'b1;
        step(10);
        chk("R6 no pulse no trip", l_prot, 0);
        pulse_on = 1'b1;
        step(BLK);
        pulse_on = 1'b0; cs_over = 1'b0;
        step(2);
        chk("R6 blanked edge ignored", l_prot, 0);
        pulse_on = 1'b1; cs_over = 1'b1;
        step(BLK);
        chk("R6 inside blanking", l_prot, 0);
        step(1);
        chk("R6 trip after blanking", l_prot, 1);
        chk("R6 trip after blanking auto", a_prot, 1);
        pulse_on = 1'b0; cs_over = 1'b0;
        supr();

        // R9 high pin locks both builds
        pin_hi = 1'b1;
        step(1);
        pin_hi = 1'b0;
        chk("R9 lock", a_prot, 1);
        step(REC + 10);
        chk("R9 no recovery", a_prot, 1);
        chk("R9 no restart", a_rst, 0);
        supr();
        chk("R9 released by supply reset", a_prot, 0);

        // R10 low pin ignored through soft-start, acted on at top code
        supr();
        pin_lo = 1'b1;
        step(5);
        pin_lo = 1'b0;
        chk("R10 ignored in soft-start", a_prot, 0);
        supr();
        step(15 * SS - 1);
        pin_lo = 1'b1;
        step(1);
        chk("R10 ignored at code 14", a_prot, 0);
        step(1);
        pin_lo = 1'b0;
        chk("R10 lock at code 15", a_prot, 1);
        chk("R10 lock latched build", l_prot, 1);
        chk("R11 setpoint zero in lock", a_sp, 0);
        supr();

        // R3 R4 R5 random period-end runs against the latched build
        for (int round = 0; round < 12; round++) begin
            bit armed = 1'b0;
            bit hit = 1'b0;
            int start = 0;
            supr();
            for (int ev = 0; ev < 40 && !hit; ev++) begin
                int unsigned gap = 1 + ($urandom % 12);
                int unsigned kind = $urandom % 10;
                for (int g = 0; g < int'(gap) && !hit; g++) begin
                    step(1);
                    chk("R3 random wait", l_prot, exp_trip(armed, start, ec));
                    hit = exp_trip(armed, start, ec);
                end
                if (!hit) begin
                    bit c = (kind < 5) ? 1'b1 : (kind < 7) ? 1'b0 : 1'($urandom % 2);
                    bit d = (kind >= 7);
                    cend(c, d);
                    chk("R4 R5 random event", l_prot, exp_trip(armed, start, ec));
                    hit = exp_trip(armed, start, ec);
                    if (!d) begin
                        if (c && !armed) begin
                            armed = 1'b1;
                            start = ec;
                        end else if (!c) begin
                            armed = 1'b0;
                        end
                    end
                end
            end
        end
        supr();
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule